// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block produces the system reset line of a CPU supervisor. A digital supply-good signal comes in from an external comparator. Reset is held from power-up, and again whenever the supply is low. It is released only after the supply has stayed good for a programmable number of timebase ticks. All timing is counted on a single-cycle tick strobe from a shared prescaler. Tests can therefore use short scaled periods while silicon counts milliseconds.

A watchdog watches the shared chip-select/kick pin. Only a high-to-low transition restarts it. A two-bit code picks one of three timeouts or switches the watchdog off. When the selected number of ticks passes without a kick, a reset pulse of fixed length is issued. The counter then restarts from zero. The watchdog is held cleared while the supply reset is active, so the two reset causes never overlap.

A volatile flag can be set and cleared by software. Because a supply reset clears it and a watchdog reset leaves it alone, boot code can read the flag to tell the two reset causes apart. A parameter selects the output polarity.

Top module: `sup_rst_gen`

## Requirements
- R1: While rst_ni is low, reset is active on sys_rst_o and flag_o is 0.
- R2: After power-up, reset stays active until HOLD_TICKS tick strobes have been sampled with pwr_good_i continuously high. It releases on the clock edge that samples the last of those ticks. Clock cycles without a tick do not advance the hold.
- R3: pwr_good_i low makes reset active in the same cycle, with no clock edge needed. The hold count restarts from zero, so a full HOLD_TICKS ticks with supply good are needed again.
- R4: Only a falling edge of cs_wdi_i (1 then 0 on consecutive clock samples) restarts the watchdog count. A rising edge, or the pin held at either level, does not.
- R5: wd_sel_i 2'b00, 2'b01 and 2'b10 select WD_LONG_TICKS, WD_MID_TICKS and WD_SHORT_TICKS. Reset becomes active on the edge that samples the selected count of ticks since the last restart.
- R6: wd_sel_i 2'b11 disables the watchdog. Selecting it ends a watchdog pulse in progress on the next clock edge.
- R7: A watchdog reset pulse lasts PULSE_TICKS ticks. After it, the watchdog counts from zero.
- R8: The watchdog is held cleared while the supply reset is active. After release, a full timeout is needed before it fires.
- R9: With RST_ACTIVE_HIGH=0 the output is low while reset is active. With RST_ACTIVE_HIGH=1 it is high while reset is active.
- R10: flag_set_i sets flag_o and flag_clr_i clears it; set wins if both are high. While the supply reset is active the flag is forced to 0 and ignores both inputs. A watchdog reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle timebase strobe |
| pwr_good_i | input | 1 | Supply above threshold (synchronous) |
| cs_wdi_i | input | 1 | Chip select; its falling edge kicks the watchdog |
| wd_sel_i | input | 2 | Watchdog timeout code |
| flag_set_i | input | 1 | Set the volatile cause flag |
| flag_clr_i | input | 1 | Clear the volatile cause flag |
| flag_o | output | 1 | Volatile cause flag |
| sys_rst_o | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |

## Verification
A supply drop shows on the output in the same cycle, so the bench checks it 1 ns after changing the input and before the next edge. Every counted result (hold release, timeout, end of a pulse) is registered once. It appears after the edge that samples the deciding tick. Each tick is driven for one cycle from a falling clock edge, and the output is checked at the next falling edge. Each count is checked one tick before its limit and again at its limit. The flag and a kick each need one edge, so they are checked one falling edge after the stimulus.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sup_hold_ctr.sv
module sup_hold_ctr #(
  parameter int unsigned HOLD_TICKS = 200,
  parameter int unsigned W          = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic good_i,
  output logic active_o
);
  logic [W-1:0] cnt_q;
  logic         act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (!good_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q && tick_i) begin
      if (cnt_q >= W'(HOLD_TICKS - 1)) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_pkg::*;
#(
  parameter int unsigned T_LONG  = 1400,
  parameter int unsigned T_MID   = 600,
  parameter int unsigned T_SHORT = 200,
  parameter int unsigned T_PULSE = 200,
  parameter int unsigned W       = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic       cs_wdi_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  logic         cs_q, kick;
  logic [W-1:0] cnt_q, limit;
  logic         fire_q;
  wd_sel_e      sel;

  assign sel  = wd_sel_e'(sel_i);
  assign kick = cs_q & ~cs_wdi_i;

  always_comb begin
    unique case (sel)
      WD_LONG:  limit = W'(T_LONG);
      WD_MID:   limit = W'(T_MID);
      WD_SHORT: limit = W'(T_SHORT);
      default:  limit = W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_wdi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (clr_i || sel == WD_OFF) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (fire_q) begin
      // pulse phase reuses the counter; kicks ignored
      if (tick_i) begin
        if (cnt_q >= W'(T_PULSE - 1)) begin
          cnt_q  <= '0;
          fire_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + W'(1);
        end
      end
    end else if (kick) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= limit - W'(1)) begin
        cnt_q  <= '0;
        fire_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/sup_flag.sv
module sup_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (hold_i)   flag_q <= 1'b0;
    else if (sw_set_i) flag_q <= 1'b1;
    else if (sw_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
  import sup_pkg::*;
#(
  parameter bit          RST_ACTIVE_HIGH = 1'b0,
  parameter int unsigned HOLD_TICKS      = 200,
  parameter int unsigned WD_LONG_TICKS   = 1400,
  parameter int unsigned WD_MID_TICKS    = 600,
  parameter int unsigned WD_SHORT_TICKS  = 200,
  parameter int unsigned PULSE_TICKS     = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwr_good_i,
  input  logic       cs_wdi_i,
  input  logic [1:0] wd_sel_i,
  input  logic       flag_set_i,
  input  logic       flag_clr_i,
  output logic       flag_o,
  output logic       sys_rst_o
);
  localparam int unsigned WD_MAX = max2(max2(WD_LONG_TICKS, WD_MID_TICKS),
                                        max2(WD_SHORT_TICKS, PULSE_TICKS));
  localparam int unsigned WD_W   = $clog2(WD_MAX + 1);
  localparam int unsigned HOLD_W = $clog2(HOLD_TICKS + 1);

  logic por_act, por_rst, wd_fire, rst_act;

  sup_hold_ctr #(.HOLD_TICKS(HOLD_TICKS), .W(HOLD_W)) u_hold (
    .clk_i, .rst_ni, .tick_i,
    .good_i  (pwr_good_i),
    .active_o(por_act)
  );

  // supply drop acts without waiting for an edge
  assign por_rst = por_act | ~pwr_good_i;

  sup_wd_timer #(
    .T_LONG(WD_LONG_TICKS), .T_MID(WD_MID_TICKS), .T_SHORT(WD_SHORT_TICKS),
    .T_PULSE(PULSE_TICKS), .W(WD_W)
  ) u_wd (
    .clk_i, .rst_ni, .tick_i,
    .clr_i   (por_rst),
    .cs_wdi_i,
    .sel_i   (wd_sel_i),
    .fire_o  (wd_fire)
  );

  sup_flag u_flag (
    .clk_i, .rst_ni,
    .hold_i  (por_rst),
    .sw_set_i(flag_set_i),
    .sw_clr_i(flag_clr_i),
    .flag_o
  );

  assign rst_act = por_rst | wd_fire;

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_hi
      assign sys_rst_o = rst_act;
    end else begin : g_pol_lo
      assign sys_rst_o = ~rst_act;
    end
  endgenerate
endmodule

// File: rtl/sup_rst_chk.sv
module sup_rst_chk #(
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       pwr_good_i,
  input logic [1:0] wd_sel_i,
  input logic       flag_set_i,
  input logic       por_act,
  input logic       wd_fire,
  input logic       flag_o,
  input logic       sys_rst_o
);
  logic out_act;
  assign out_act = RST_ACTIVE_HIGH ? sys_rst_o : ~sys_rst_o;

  // R3
  pwr_low_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> out_act);

  // R2
  hold_release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_act) |-> $past(tick_i));

  // R8
  wd_quiet_in_por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_act |=> !wd_fire);

  // R6
  wd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == 2'b11) |=> !wd_fire);

  // R10
  flag_por_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_act || !pwr_good_i) |=> !flag_o);

  // R10
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_i && pwr_good_i && !por_act) |=> flag_o);

  // R9
  wd_drives_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |-> out_act);
endmodule

bind sup_rst_gen sup_rst_chk #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_chk (
  .clk_i, .rst_ni, .tick_i, .pwr_good_i, .wd_sel_i, .flag_set_i,
  .por_act, .wd_fire, .flag_o, .sys_rst_o
);

// File: tb/tb_sup_rst_gen.sv
module tb_sup_rst_gen;
  localparam int unsigned HOLD = 5, TL = 14, TM = 6, TS = 3, TP = 5;

  logic clk = 1'b0;
  logic rst_ni, tick_i, pwr_good_i, cs_wdi_i, flag_set_i, flag_clr_i;
  logic [1:0] wd_sel_i;
  logic flag_o, sys_rst_o, flag_hi, rst_hi;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sup_rst_gen #(.RST_ACTIVE_HIGH(1'b0), .HOLD_TICKS(HOLD), .WD_LONG_TICKS(TL),
    .WD_MID_TICKS(TM), .WD_SHORT_TICKS(TS), .PULSE_TICKS(TP)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .pwr_good_i, .cs_wdi_i, .wd_sel_i,
    .flag_set_i, .flag_clr_i, .flag_o, .sys_rst_o);

  sup_rst_gen #(.RST_ACTIVE_HIGH(1'b1), .HOLD_TICKS(HOLD), .WD_LONG_TICKS(TL),
    .WD_MID_TICKS(TM), .WD_SHORT_TICKS(TS), .PULSE_TICKS(TP)) dut_hi (
    .clk_i(clk), .rst_ni, .tick_i, .pwr_good_i, .cs_wdi_i, .wd_sel_i,
    .flag_set_i, .flag_clr_i, .flag_o(flag_hi), .sys_rst_o(rst_hi));

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] n;
    logic       exp;
  } vec_t;

  // sel, ticks after kick, reset expected
  localparam vec_t VECS [7] = '{
    '{2'b00, 8'd13, 1'b0}, '{2'b00, 8'd14, 1'b1},
    '{2'b01, 8'd5,  1'b0}, '{2'b01, 8'd6,  1'b1},
    '{2'b10, 8'd2,  1'b0}, '{2'b10, 8'd3,  1'b1},
    '{2'b11, 8'd40, 1'b0}
  };

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic chk_rst(input logic exp, input string req, input string what);
    chk(sys_rst_o, ~exp, req, what);
    chk(rst_hi, exp, "R9", {what, " (active-high)"});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic kick();
    @(negedge clk); cs_wdi_i = 1'b1;
    @(negedge clk); cs_wdi_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; pwr_good_i = 1'b0; cs_wdi_i = 1'b1;
    wd_sel_i = 2'b10; flag_set_i = 1'b0; flag_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_rst(1'b1, "R1", "reset state");
    chk(flag_o, 1'b0, "R1", "flag in reset");
    rst_ni = 1'b1; pwr_good_i = 1'b1;
    repeat (10) @(negedge clk);
    chk_rst(1'b1, "R2", "no tick no release");
    tick(HOLD - 1);
    chk_rst(1'b1, "R2", "hold minus one");
    tick(1);
    chk_rst(1'b0, "R2", "hold released");
    tick(TS - 1);
    chk_rst(1'b0, "R8", "wd cleared during hold");
    tick(1);
    chk_rst(1'b1, "R5", "short timeout fires");
    tick(TP - 1);
    chk_rst(1'b1, "R7", "pulse minus one");
    tick(1);
    chk_rst(1'b0, "R7", "pulse ended");
    tick(TS - 1);
    chk_rst(1'b0, "R7", "restart from zero");
    tick(1);
    chk_rst(1'b1, "R7", "refire after restart");
    tick(TP);

    // R4 R5 R6 vector walk
    foreach (VECS[i]) begin
      wd_sel_i = VECS[i].sel;
      kick();
      tick(int'(VECS[i].n));
      chk_rst(VECS[i].exp, VECS[i].exp ? "R5" : "R4", $sformatf("vec %0d", i));
      if (VECS[i].exp) begin
        tick(TP);
        chk_rst(1'b0, "R7", $sformatf("vec %0d pulse end", i));
      end
    end

    // R4 rising edge does not restart
    wd_sel_i = 2'b10;
    kick();
    tick(TS - 1);
    @(negedge clk); cs_wdi_i = 1'b1;
    tick(1);
    chk_rst(1'b1, "R4", "rising edge ignored");
    tick(TP);

    // R6 off ends pulse
    kick();
    tick(TS);
    chk_rst(1'b1, "R6", "fired before off");
    @(negedge clk); wd_sel_i = 2'b11;
    @(negedge clk);
    chk_rst(1'b0, "R6", "off ends pulse");
    wd_sel_i = 2'b10;
    kick();

    // R10 flag
    @(negedge clk); flag_set_i = 1'b1;
    @(negedge clk); flag_set_i = 1'b0;
    chk(flag_o, 1'b1, "R10", "flag set");
    flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    chk(flag_o, 1'b0, "R10", "flag clear");
    flag_set_i = 1'b1; flag_clr_i = 1'b1;
    @(negedge clk); flag_set_i = 1'b0; flag_clr_i = 1'b0;
    chk(flag_o, 1'b1, "R10", "set wins");
    kick();
    tick(TS);
    chk_rst(1'b1, "R5", "fire with flag");
    chk(flag_o, 1'b1, "R10", "flag kept by wd reset");
    tick(TP);

    // R3 brownout
    @(negedge clk); pwr_good_i = 1'b0;
    #1;
    chk_rst(1'b1, "R3", "same-cycle assert");
    flag_set_i = 1'b1;
    @(negedge clk); flag_set_i = 1'b0;
    chk(flag_o, 1'b0, "R10", "flag cleared, set ignored in brownout");
    pwr_good_i = 1'b1;
    tick(HOLD - 1);
    chk_rst(1'b1, "R3", "partial hold");
    @(negedge clk); pwr_good_i = 1'b0;
    @(negedge clk); pwr_good_i = 1'b1;
    tick(HOLD - 1);
    chk_rst(1'b1, "R3", "hold restarted");
    tick(1);
    chk_rst(1'b0, "R3", "release after full hold");
    tick(TS - 1);
    chk_rst(1'b0, "R8", "wd zero after brownout");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule